// File: doc/BRIEF.md
# Console Command Slave

This block is a small bus slave that turns register writes into commands for a text and graphics console. Software first places an operand in a 64-bit operand register. It then writes a command code to a 32-bit command register. The write to the command register starts the command, and the command works on whatever the operand register holds at that moment.

Most commands produce one event for a console model, using a valid/ready handshake. An event can print a number, plot a pixel or clear a screen. Values are passed on raw: text rendering and floating-point formatting are left to the console model.

The string command reads bytes from memory through a read port, one byte per request, and forwards each byte as its own event. Two input commands send a request event and then wait for a reply, which is stored in the operand register. While a command is running, the slave stalls every bus access.

Top module: `conio_cmd_slave`

## Requirements
- R1: The command register is decoded at byte address 0x10000 and the operand register at 0x10008. When the block is idle, both can be written and read back. A read of the command register returns the 32 bits written, zero-extended. Reads of any other address return zero, and writes to any other address change nothing.
- R2: Writing code 1, 2 or 3 to the command register starts a command. On the next clock, ev_valid rises with ev_kind equal to the code (1 = unsigned integer, 2 = signed integer, 3 = double value) and ev_data equal to the operand.
- R3: Code 5 gives a kind-5 pixel event. px_x is operand bits 47:40, px_y is operand bits 39:32, and px_rgb is operand bits 23:0.
- R4: Code 6 gives a kind-6 event that clears the text screen. Code 7 gives a kind-7 event that clears the graphics screen.
- R5: Code 4 reads memory bytes with single-cycle mem_rd_req pulses. The first address is operand bits 15:0, and the address goes up by one for each byte. Each nonzero byte is sent as a kind-4 event, with the byte in ev_data[7:0] and the upper bits of ev_data zero. The first zero byte ends the command and sends no event. The operand register is left unchanged.
- R6: Code 8 sends a kind-8 request event, then waits for in_valid. The operand register is then loaded with the full in_data.
- R7: Code 9 sends a kind-9 request event. The operand register is then loaded with in_data[7:0], zero-extended.
- R8: From the clock after a command starts until the command finishes, bus_ready is low. No bus access is accepted in that time, and a write attempted then has no effect.
- R9: A command-register value outside 1..9, judged on all 32 bits, starts nothing. No event is produced, and bus_ready stays high.
- R10: While ev_valid is high and ev_ready is low, ev_valid, ev_kind and ev_data hold steady.
- R11: After reset, bus_ready is 1, ev_valid is 0, mem_rd_req is 0, and both registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_ready | output | 1 | Access accepted this cycle; low while a command runs |
| bus_rdata | output | 64 | Read data for bus_addr |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Console accepts the event |
| ev_kind | output | 4 | Event kind, equal to the command code |
| ev_data | output | 64 | Operand value, or a string byte in bits 7:0 |
| px_x | output | 8 | Pixel x coordinate |
| px_y | output | 8 | Pixel y coordinate |
| px_rgb | output | 24 | Pixel colour |
| mem_rd_req | output | 1 | One-cycle request for a string byte |
| mem_rd_addr | output | 16 | Byte address for the request |
| mem_rd_valid | input | 1 | Memory reply present |
| mem_rd_data | input | 8 | Byte returned by memory |
| in_valid | input | 1 | Input reply present |
| in_data | input | 64 | Input value |

## Verification
The bench writes command values whose low nibble is a valid code but whose upper bits are set. A decoder that looks only at the low bits would start a command on these values and raise ev_valid.

Strings are checked in two cases: an empty string, and a string that ends on a zero byte. A sequencer that sends the terminator as an event, or that stops one byte early, produces the wrong character count or the wrong number of memory requests.

Under event backpressure, the bench keeps a write to the operand register pending. A slave that accepts writes while busy would corrupt the operand or change ev_data. The single-byte input command is fed a value with all upper bits set, which catches a design that fails to zero-extend the byte.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

   typedef enum logic [3:0] {
      EVK_NONE     = 4'd0,
      EVK_UINT     = 4'd1,
      EVK_SINT     = 4'd2,
      EVK_REAL     = 4'd3,
      EVK_CHAR     = 4'd4,
      EVK_PIXEL    = 4'd5,
      EVK_CLR_TEXT = 4'd6,
      EVK_CLR_GFX  = 4'd7,
      EVK_GET_NUM  = 4'd8,
      EVK_GET_KEY  = 4'd9
   } evk_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EMIT,
      ST_AWAIT_IN,
      ST_FETCH,
      ST_MWAIT,
      ST_CHAR
   } st_e;

   localparam int CODE_W  = 4;
   localparam int MAX_CODE = 9;

endpackage

// File: rtl/ccs_bus_regs.sv
module ccs_bus_regs #(
   parameter int          BUS_AW    = 20,
   parameter int          DATA_W    = 64,
   parameter int          CTRL_W    = 32,
   parameter int unsigned CTRL_ADDR = 32'h10000,
   parameter int unsigned DATA_ADDR = 32'h10008
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_valid,
   input  logic                      bus_write,
   input  logic [BUS_AW-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   input  logic                      busy,
   input  logic                      ld_en,
   input  logic [DATA_W-1:0]         ld_val,
   output logic                      bus_ready,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic                      start,
   output logic [ccs_pkg::CODE_W-1:0] start_code,
   output logic [DATA_W-1:0]         data_q
);
   import ccs_pkg::*;

   if (CTRL_W < CODE_W || CTRL_W > DATA_W) begin : g_bad_ctrl_w
      $error("ccs_bus_regs: CTRL_W must lie between the code width and DATA_W");
   end
   if (CTRL_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("ccs_bus_regs: command and operand addresses collide");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic              hit_ctrl, hit_data, acc_wr, code_ok;

   assign hit_ctrl  = (bus_addr == BUS_AW'(CTRL_ADDR));
   assign hit_data  = (bus_addr == BUS_AW'(DATA_ADDR));
   assign bus_ready = !busy;
   assign acc_wr    = bus_valid && bus_write && !busy;
   assign code_ok   = (bus_wdata[CTRL_W-1:0] != '0) &&
                      (bus_wdata[CTRL_W-1:0] <= CTRL_W'(MAX_CODE));

   assign start      = acc_wr && hit_ctrl && code_ok;
   assign start_code = bus_wdata[CODE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
      end else begin
         if (acc_wr && hit_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (ld_en)                    data_q <= ld_val;
         else if (acc_wr && hit_data)  data_q <= bus_wdata;
      end
   end

   always_comb begin
      if (hit_ctrl)      bus_rdata = DATA_W'(ctrl_q);
      else if (hit_data) bus_rdata = data_q;
      else               bus_rdata = '0;
   end

endmodule

// File: rtl/ccs_cmd_fsm.sv
module ccs_cmd_fsm #(
   parameter int DATA_W = 64,
   parameter int MEM_AW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ccs_pkg::CODE_W-1:0] start_code,
   input  logic [MEM_AW-1:0]          ptr_init,
   input  logic                       ev_ready,
   input  logic                       mem_rd_valid,
   input  logic [7:0]                 mem_rd_data,
   input  logic                       in_valid,
   input  logic [DATA_W-1:0]          in_data,
   output logic                       busy,
   output logic                       ev_valid,
   output logic [3:0]                 ev_kind,
   output logic                       char_sel,
   output logic [7:0]                 char_q,
   output logic                       mem_rd_req,
   output logic [MEM_AW-1:0]          mem_rd_addr,
   output logic                       ld_en,
   output logic [DATA_W-1:0]          ld_val
);
   import ccs_pkg::*;

   if (DATA_W < 16 || MEM_AW < 1 || MEM_AW > DATA_W) begin : g_bad_widths
      $error("ccs_cmd_fsm: MEM_AW must fit inside DATA_W");
   end

   st_e               st_q;
   evk_e              kind_q;
   logic [MEM_AW-1:0] ptr_q;
   logic              wants_input;

   assign wants_input = (kind_q == EVK_GET_NUM) || (kind_q == EVK_GET_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= EVK_NONE;
         ptr_q  <= '0;
         char_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               kind_q <= evk_e'(start_code);
               if (evk_e'(start_code) == EVK_CHAR) begin
                  ptr_q <= ptr_init;
                  st_q  <= ST_FETCH;
               end else begin
                  st_q  <= ST_EMIT;
               end
            end
            ST_EMIT: if (ev_ready) st_q <= wants_input ? ST_AWAIT_IN : ST_IDLE;
            ST_AWAIT_IN: if (in_valid) st_q <= ST_IDLE;
            ST_FETCH: st_q <= ST_MWAIT;
            ST_MWAIT: if (mem_rd_valid) begin
               if (mem_rd_data == 8'd0) begin
                  st_q <= ST_IDLE;
               end else begin
                  char_q <= mem_rd_data;
                  st_q   <= ST_CHAR;
               end
            end
            ST_CHAR: if (ev_ready) begin
               ptr_q <= ptr_q + MEM_AW'(1);
               st_q  <= ST_FETCH;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign ev_valid    = (st_q == ST_EMIT) || (st_q == ST_CHAR);
   assign char_sel    = (st_q == ST_CHAR);
   assign ev_kind     = char_sel ? EVK_CHAR : kind_q;
   assign mem_rd_req  = (st_q == ST_FETCH);
   assign mem_rd_addr = ptr_q;
   assign ld_en       = (st_q == ST_AWAIT_IN) && in_valid;
   assign ld_val      = (kind_q == EVK_GET_KEY) ?
                        {{(DATA_W-8){1'b0}}, in_data[7:0]} : in_data;

endmodule

// File: rtl/ccs_evt_out.sv
module ccs_evt_out #(
   parameter int DATA_W    = 64,
   parameter int X_LANE    = 5,
   parameter int Y_LANE    = 4,
   parameter int RGB_LANES = 3,
   localparam int RGB_W    = 8 * RGB_LANES,
   localparam int LANES    = DATA_W / 8
) (
   input  logic [DATA_W-1:0] data_q,
   input  logic              char_sel,
   input  logic [7:0]        char_q,
   output logic [DATA_W-1:0] ev_data,
   output logic [7:0]        px_x,
   output logic [7:0]        px_y,
   output logic [RGB_W-1:0]  px_rgb
);

   if (X_LANE >= LANES || Y_LANE >= LANES || X_LANE == Y_LANE) begin : g_bad_xy
      $error("ccs_evt_out: coordinate lanes out of range or overlapping");
   end
   if (RGB_LANES < 1 || RGB_LANES > X_LANE || RGB_LANES > Y_LANE) begin : g_bad_rgb
      $error("ccs_evt_out: colour lanes must sit below the coordinate lanes");
   end

   for (genvar i = 0; i < RGB_LANES; i++) begin : g_rgb_lane
      assign px_rgb[8*i +: 8] = data_q[8*i +: 8];
   end

   assign px_x    = data_q[8*X_LANE +: 8];
   assign px_y    = data_q[8*Y_LANE +: 8];
   assign ev_data = char_sel ? {{(DATA_W-8){1'b0}}, char_q} : data_q;

endmodule

// File: rtl/conio_cmd_slave.sv
module conio_cmd_slave #(
   parameter int          BUS_AW    = 20,
   parameter int          DATA_W    = 64,
   parameter int          CTRL_W    = 32,
   parameter int          MEM_AW    = 16,
   parameter int unsigned CTRL_ADDR = 32'h10000,
   parameter int unsigned DATA_ADDR = 32'h10008,
   parameter int          PX_X_LANE = 5,
   parameter int          PX_Y_LANE = 4,
   parameter int          RGB_LANES = 3,
   localparam int         RGB_W     = 8 * RGB_LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ready,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ev_valid,
   input  logic              ev_ready,
   output logic [3:0]        ev_kind,
   output logic [DATA_W-1:0] ev_data,
   output logic [7:0]        px_x,
   output logic [7:0]        px_y,
   output logic [RGB_W-1:0]  px_rgb,
   output logic              mem_rd_req,
   output logic [MEM_AW-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [7:0]        mem_rd_data,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data
);
   import ccs_pkg::*;

   logic                busy, start, ld_en, char_sel;
   logic [CODE_W-1:0]   start_code;
   logic [DATA_W-1:0]   data_q, ld_val;
   logic [7:0]          char_q;

   ccs_bus_regs #(
      .BUS_AW(BUS_AW), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
      .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .busy(busy), .ld_en(ld_en), .ld_val(ld_val),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .start(start), .start_code(start_code), .data_q(data_q)
   );

   ccs_cmd_fsm #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) fsm_i (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_code(start_code),
      .ptr_init(data_q[MEM_AW-1:0]),
      .ev_ready(ev_ready),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .in_valid(in_valid), .in_data(in_data),
      .busy(busy), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .char_sel(char_sel), .char_q(char_q),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .ld_en(ld_en), .ld_val(ld_val)
   );

   ccs_evt_out #(
      .DATA_W(DATA_W), .X_LANE(PX_X_LANE), .Y_LANE(PX_Y_LANE),
      .RGB_LANES(RGB_LANES)
   ) evt_i (
      .data_q(data_q), .char_sel(char_sel), .char_q(char_q),
      .ev_data(ev_data), .px_x(px_x), .px_y(px_y), .px_rgb(px_rgb)
   );

endmodule

// File: rtl/ccs_chk.sv
module ccs_chk #(
   parameter int          BUS_AW    = 20,
   parameter int          DATA_W    = 64,
   parameter int          CTRL_W    = 32,
   parameter int unsigned CTRL_ADDR = 32'h10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ready,
   input logic              ev_valid,
   input logic              ev_ready,
   input logic [3:0]        ev_kind,
   input logic [DATA_W-1:0] ev_data,
   input logic              mem_rd_req
);

   logic wr_ctrl, known, is_str;

   assign wr_ctrl = bus_valid && bus_ready && bus_write &&
                    (bus_addr == BUS_AW'(CTRL_ADDR));
   assign known   = (bus_wdata[CTRL_W-1:0] != '0) &&
                    (bus_wdata[CTRL_W-1:0] <= CTRL_W'(9));
   assign is_str  = (bus_wdata[3:0] == 4'd4);

   AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && !ev_ready |=> ev_valid && $stable(ev_kind) && $stable(ev_data)); // R10
   AST_STALL_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> !bus_ready); // R8
   AST_STALL_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !bus_ready); // R8
   AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && !known |=> bus_ready && !ev_valid); // R9
   AST_KNOWN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && known && !is_str |=> ev_valid); // R2
   AST_NO_TERMINATOR: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && (ev_kind == 4'd4) |->
         (ev_data[7:0] != 8'd0) && (ev_data[DATA_W-1:8] == '0)); // R5
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req); // R5

endmodule

bind conio_cmd_slave ccs_chk #(
   .BUS_AW(BUS_AW), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
   .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
   .ev_data(ev_data), .mem_rd_req(mem_rd_req)
);

// File: tb/conio_cmd_slave_tb_top.sv
module conio_cmd_slave_tb_top;

   localparam logic [19:0] A_CTRL = 20'h10000;
   localparam logic [19:0] A_DATA = 20'h10008;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [19:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic        bus_ready;
   logic [63:0] bus_rdata;
   logic        ev_valid;
   logic        ev_ready = 1'b1;
   logic [3:0]  ev_kind;
   logic [63:0] ev_data;
   logic [7:0]  px_x, px_y;
   logic [23:0] px_rgb;
   logic        mem_rd_req;
   logic [15:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [7:0]  mem_rd_data = '0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   conio_cmd_slave dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
      .ev_data(ev_data), .px_x(px_x), .px_y(px_y), .px_rgb(px_rgb),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .in_valid(in_valid), .in_data(in_data)
   );

   // memory model: two negedges of latency after a request is seen
   logic [7:0]  tb_mem [64];
   int          m_cnt = 0;
   logic [5:0]  m_addr = '0;
   int          n_req = 0;
   logic [15:0] req_first, req_last;
   int          n_chars = 0;
   logic [7:0]  str_log [8];

   always @(negedge clk) begin
      mem_rd_valid <= 1'b0;
      if (m_cnt == 1) begin
         mem_rd_valid <= 1'b1;
         mem_rd_data  <= tb_mem[m_addr];
      end
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
      if (mem_rd_req) begin
         m_cnt  <= 2;
         m_addr <= mem_rd_addr[5:0];
         if (n_req == 0) req_first = mem_rd_addr;
         req_last = mem_rd_addr;
         n_req++;
      end
      if (ev_valid && ev_ready && ev_kind == 4'd4) begin
         if (n_chars < 8) str_log[n_chars] = ev_data[7:0];
         n_chars++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [19:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      while (!bus_ready) @(negedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [19:0] a, output logic [63:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      while (!bus_ready) @(negedge clk);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   // table: {code, operand}
   localparam logic [67:0] VEC [6] = '{
      {4'd1, 64'hFFFF_FFFF_FFFF_FFFE},
      {4'd2, 64'h8000_0000_0000_0001},
      {4'd3, 64'h4009_21FB_5444_2D18},
      {4'd5, 64'h0000_2A17_00C0_FFEE},
      {4'd6, 64'h0000_0000_0000_1234},
      {4'd7, 64'h0000_0000_0000_0000}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [63:0] rd;
      for (int i = 0; i < 64; i++) tb_mem[i] = 8'd0;
      tb_mem[6'h20] = "H"; tb_mem[6'h21] = "i"; tb_mem[6'h22] = "!";

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 bus_ready", 64'(bus_ready), 64'd1);
      chk("R11 ev_valid", 64'(ev_valid), 64'd0);
      chk("R11 mem_rd_req", 64'(mem_rd_req), 64'd0);
      bus_rd(A_DATA, rd); chk("R11 operand", rd, 64'd0);
      bus_rd(A_CTRL, rd); chk("R11 command", rd, 64'd0);

      // table of one-event commands: R2 R3 R4
      for (int v = 0; v < 6; v++) begin
         logic [3:0]  code;
         logic [63:0] opnd;
         string       tag;
         code = VEC[v][67:64];
         opnd = VEC[v][63:0];
         tag  = (code == 4'd5) ? "R3" : (code >= 4'd6) ? "R4" : "R2";
         bus_wr(A_DATA, opnd);
         bus_wr(A_CTRL, 64'(code));
         chk({tag, " ev_valid"}, 64'(ev_valid), 64'd1);
         chk({tag, " ev_kind"}, 64'(ev_kind), 64'(code));
         chk({tag, " ev_data"}, ev_data, opnd);
         if (code == 4'd5) begin
            chk("R3 px_x", 64'(px_x), 64'(opnd[47:40]));
            chk("R3 px_y", 64'(px_y), 64'(opnd[39:32]));
            chk("R3 px_rgb", 64'(px_rgb), 64'(opnd[23:0]));
         end
         @(negedge clk);
         chk({tag, " done"}, 64'({ev_valid, bus_ready}), 64'b01);
      end

      // R1 decode: stray address
      bus_wr(A_DATA, 64'h1111_2222_3333_4444);
      bus_wr(20'h10010, 64'hDEAD);
      bus_rd(A_DATA, rd); chk("R1 stray write", rd, 64'h1111_2222_3333_4444);
      bus_rd(20'h10010, rd); chk("R1 stray read", rd, 64'd0);

      // R9 unknown codes, including upper bits set
      bus_wr(A_CTRL, 64'd0);
      chk("R9 code0", 64'({ev_valid, bus_ready}), 64'b01);
      bus_wr(A_CTRL, 64'd10);
      chk("R9 code10", 64'({ev_valid, bus_ready}), 64'b01);
      bus_wr(A_CTRL, 64'h1_0001);
      chk("R9 upper bits", 64'({ev_valid, bus_ready}), 64'b01);
      @(negedge clk);
      chk("R9 still idle", 64'({ev_valid, bus_ready}), 64'b01);
      bus_rd(A_CTRL, rd); chk("R1 command readback", rd, 64'h1_0001);

      // R10 / R8 backpressure with a pending write
      ev_ready = 1'b0;
      bus_wr(A_DATA, 64'h77);
      bus_wr(A_CTRL, 64'd1);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_DATA; bus_wdata = 64'h99;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 hold", 64'({ev_valid, ev_kind}), 64'h11);
         chk("R10 hold data", ev_data, 64'h77);
         chk("R8 stalled", 64'(bus_ready), 64'd0);
      end
      bus_valid = 1'b0; bus_write = 1'b0;
      ev_ready = 1'b1;
      @(negedge clk);
      chk("R10 released", 64'(ev_valid), 64'd0);
      bus_rd(A_DATA, rd); chk("R8 write blocked", rd, 64'h77);

      // R5 string
      n_req = 0; n_chars = 0;
      bus_wr(A_DATA, 64'hABCD_0000_0000_0020);
      bus_wr(A_CTRL, 64'd4);
      chk("R8 busy during fetch", 64'(bus_ready), 64'd0);
      bus_rd(A_DATA, rd);
      chk("R5 operand kept", rd, 64'hABCD_0000_0000_0020);
      chk("R5 char count", 64'(n_chars), 64'd3);
      chk("R5 chars", {40'd0, str_log[0], str_log[1], str_log[2]}, {40'd0, "Hi!"});
      chk("R5 requests", 64'(n_req), 64'd4);
      chk("R5 first addr", 64'(req_first), 64'h20);
      chk("R5 last addr", 64'(req_last), 64'h23);

      // R5 empty string
      n_req = 0; n_chars = 0;
      bus_wr(A_DATA, 64'h30);
      bus_wr(A_CTRL, 64'd4);
      bus_rd(A_DATA, rd);
      chk("R5 empty chars", 64'(n_chars), 64'd0);
      chk("R5 empty requests", 64'(n_req), 64'd1);

      // R6 read number
      bus_wr(A_DATA, 64'h55);
      bus_wr(A_CTRL, 64'd8);
      chk("R6 request", 64'({ev_valid, ev_kind}), 64'h18);
      repeat (3) @(negedge clk);
      chk("R6 waiting", 64'({ev_valid, bus_ready}), 64'b00);
      in_valid = 1'b1; in_data = 64'hDEAD_BEEF_0123_4567;
      @(negedge clk);
      in_valid = 1'b0;
      bus_rd(A_DATA, rd); chk("R6 loaded", rd, 64'hDEAD_BEEF_0123_4567);

      // R7 read one byte
      bus_wr(A_CTRL, 64'd9);
      chk("R7 request", 64'({ev_valid, ev_kind}), 64'h19);
      @(negedge clk);
      in_valid = 1'b1; in_data = 64'hFFFF_FFFF_FFFF_FFA5;
      @(negedge clk);
      in_valid = 1'b0;
      bus_rd(A_DATA, rd); chk("R7 zero-extended", rd, 64'hA5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule